// File: doc/BRIEF.md
# Dual-Width Integer Execute ALU

This block is the combinational integer unit of the execute stage in a 64-bit register machine. One operation code picks the function. Two 64-bit source operands and a 16-bit immediate feed it. In the same cycle it returns a 64-bit result, a write-enable for the destination register and an overflow-trap flag. Both 32-bit word variants and 64-bit doubleword variants run on the same 64-bit adder and the same 64-bit shifter. A word result is formed on bits 31:0 and then sign-extended to the full register width.

The pipeline around the block uses `wr_en` to decide whether the destination register is updated. It uses `ovf_trap` to raise an arithmetic exception. A signed add or subtract that overflows never writes its destination. A conditional move whose condition fails also leaves the destination alone. Operation codes that are not listed below are inert.

Top module: `alu_dual_width`

## Requirements
- R1: The add and subtract forms return the two's-complement wrapped sum `op_a + x` or difference `op_a - op_b`, where x is `op_b` for register forms and the 16-bit immediate sign-extended for immediate forms. The word forms take bits 31:0 and sign-extend bit 31 into bits 63:32. The codes are: 0/1 word add, 2/3 doubleword add, 4/5 word subtract, 6/7 doubleword subtract, 8/9 word add-immediate and 10/11 doubleword add-immediate. In each pair the even code is the trapping form. The result carries the wrapped value even when a trap is raised.
- R2: The trapping forms (codes 0, 2, 4, 6, 8, 10) raise `ovf_trap` exactly when signed overflow occurs. The sign is taken at bit 31 for word forms and at bit 63 for doubleword forms. Whenever `ovf_trap` is high, `wr_en` is low. Otherwise `wr_en` is high.
- R3: The non-trapping add and subtract forms (codes 1, 3, 5, 7, 9, 11) never raise `ovf_trap` and always assert `wr_en`.
- R4: Codes 12, 13 and 14 give the bitwise AND, OR and XOR of `op_a` and `op_b`. Codes 15, 16 and 17 apply the same operations to `op_a` and the immediate zero-extended to 64 bits.
- R5: Code 18 returns 1 when `op_a` is less than `op_b` as signed 64-bit values and 0 otherwise. Code 19 makes the same test on unsigned values.
- R6: Code 20 (signed) and code 21 (unsigned) compare `op_a` with the immediate after it has been sign-extended to 64 bits. They return 1 or 0 as in R5.
- R7: Code 22 asserts `wr_en` only when `op_b` is non-zero. Code 23 asserts it only when `op_b` is zero. Both present `op_a` on `result` and never trap.
- R8: Code 24 places the immediate in bits 31:16 and zeros in bits 15:0. Bits 63:32 are copies of bit 31.
- R9: Shift codes are 32 + k (amount from the immediate) and 40 + k (amount from `op_b`). Here k = 0, 1, 2 are the word left, logical-right and arithmetic-right shifts, and k = 3, 4, 5 are the doubleword versions. The amount is the unsigned value of the low 5 bits for word shifts and of the low 6 bits for doubleword shifts. Logical shifts fill with zeros. Arithmetic shifts fill with copies of the top bit of the shifted value (bit 31 for word, bit 63 for doubleword).
- R10: A word shift acts on `op_a[31:0]`. Its 32-bit result is sign-extended from bit 31 into bits 63:32.
- R11: Every code not named above returns a zero `result`, keeps `wr_en` low and keeps `ovf_trap` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_code | input | 6 | Operation select |
| op_a | input | 64 | First source operand, also the value that is shifted |
| op_b | input | 64 | Second source operand, shift amount for register shifts, condition for moves |
| imm | input | 16 | Immediate field |
| result | output | 64 | Computed value |
| wr_en | output | 1 | Destination write permitted |
| ovf_trap | output | 1 | Signed-overflow exception |

## Verification
Two things land in the same evaluation: the overflow trap and the suppression of the destination write. A trapping add or subtract whose operands sit at the signed limits raises both at once while still returning the wrapped sum. The sweep provokes this with operands at 0x7fffffff, 0x80000000 and the 64-bit extremes, crossed with every operation code and several immediates. Every vector judges the result, `wr_en` and `ovf_trap` together against an arithmetic model. The sweep also catches the signed compare on overflowing differences, because that compare is taken from the same subtraction that drives the trap.

// File: rtl/alu_dw_pkg.sv
package alu_dw_pkg;

    localparam int XLEN = 64;
    localparam int WLEN = 32;
    localparam int IMMW = 16;
    localparam int OPW  = 6;
    localparam int SHW  = $clog2(XLEN);
    localparam int WSHW = $clog2(WLEN);

    typedef enum logic [OPW-1:0] {
        OP_ADD_W_TRAP  = 6'd0,
        OP_ADD_W       = 6'd1,
        OP_ADD_D_TRAP  = 6'd2,
        OP_ADD_D       = 6'd3,
        OP_SUB_W_TRAP  = 6'd4,
        OP_SUB_W       = 6'd5,
        OP_SUB_D_TRAP  = 6'd6,
        OP_SUB_D       = 6'd7,
        OP_ADDI_W_TRAP = 6'd8,
        OP_ADDI_W      = 6'd9,
        OP_ADDI_D_TRAP = 6'd10,
        OP_ADDI_D      = 6'd11,
        OP_AND         = 6'd12,
        OP_OR          = 6'd13,
        OP_XOR         = 6'd14,
        OP_ANDI        = 6'd15,
        OP_ORI         = 6'd16,
        OP_XORI        = 6'd17,
        OP_LT_S        = 6'd18,
        OP_LT_U        = 6'd19,
        OP_LTI_S       = 6'd20,
        OP_LTI_U       = 6'd21,
        OP_MOV_NZ      = 6'd22,
        OP_MOV_Z       = 6'd23,
        OP_UPPER_IMM   = 6'd24
    } alu_op_e;

    // Shift group: bit 5 set, bit 4 clear, bit 3 selects register amount,
    // bits 2:0 give the kind (0..2 word, 3..5 doubleword).
    localparam logic [OPW-1:0] OP_SHIFT_BASE = 6'd32;
    localparam logic [OPW-1:0] OP_SHIFT_REG  = 6'd8;

    typedef enum logic [2:0] {
        UNIT_NONE,
        UNIT_ADD,
        UNIT_LOGIC,
        UNIT_CMP,
        UNIT_MOVE,
        UNIT_UPPER,
        UNIT_SHIFT
    } unit_e;

    typedef enum logic [1:0] {
        LG_AND,
        LG_OR,
        LG_XOR
    } logic_fn_e;

    typedef struct packed {
        unit_e     unit;
        logic      sub;
        logic      word;
        logic      imm_src;
        logic      imm_zext;
        logic      trap_en;
        logic_fn_e lfn;
        logic      cmp_uns;
        logic      mov_zero;
        logic      sh_left;
        logic      sh_arith;
        logic      sh_reg;
    } alu_ctrl_t;

    function automatic logic [XLEN-1:0] sext_word(input logic [XLEN-1:0] v);
        return {{(XLEN-WLEN){v[WLEN-1]}}, v[WLEN-1:0]};
    endfunction

    function automatic logic [XLEN-1:0] bit_reverse(input logic [XLEN-1:0] v);
        logic [XLEN-1:0] r;
        for (int i = 0; i < XLEN; i++) begin
            r[i] = v[XLEN-1-i];
        end
        return r;
    endfunction

endpackage

// File: rtl/alu_dw_decode.sv
module alu_dw_decode
    import alu_dw_pkg::*;
(
    input  logic [OPW-1:0] op_code,
    output alu_ctrl_t      ctrl
);

    logic [2:0] sh_kind;
    assign sh_kind = op_code[2:0];

    always_comb begin
        ctrl      = '0;
        ctrl.unit = UNIT_NONE;
        ctrl.lfn  = LG_AND;
        case (op_code)
            OP_ADD_W_TRAP:  begin ctrl.unit = UNIT_ADD; ctrl.word = 1'b1; ctrl.trap_en = 1'b1; end
            OP_ADD_W:       begin ctrl.unit = UNIT_ADD; ctrl.word = 1'b1; end
            OP_ADD_D_TRAP:  begin ctrl.unit = UNIT_ADD; ctrl.trap_en = 1'b1; end
            OP_ADD_D:       begin ctrl.unit = UNIT_ADD; end
            OP_SUB_W_TRAP:  begin ctrl.unit = UNIT_ADD; ctrl.sub = 1'b1; ctrl.word = 1'b1; ctrl.trap_en = 1'b1; end
            OP_SUB_W:       begin ctrl.unit = UNIT_ADD; ctrl.sub = 1'b1; ctrl.word = 1'b1; end
            OP_SUB_D_TRAP:  begin ctrl.unit = UNIT_ADD; ctrl.sub = 1'b1; ctrl.trap_en = 1'b1; end
            OP_SUB_D:       begin ctrl.unit = UNIT_ADD; ctrl.sub = 1'b1; end
            OP_ADDI_W_TRAP: begin ctrl.unit = UNIT_ADD; ctrl.imm_src = 1'b1; ctrl.word = 1'b1; ctrl.trap_en = 1'b1; end
            OP_ADDI_W:      begin ctrl.unit = UNIT_ADD; ctrl.imm_src = 1'b1; ctrl.word = 1'b1; end
            OP_ADDI_D_TRAP: begin ctrl.unit = UNIT_ADD; ctrl.imm_src = 1'b1; ctrl.trap_en = 1'b1; end
            OP_ADDI_D:      begin ctrl.unit = UNIT_ADD; ctrl.imm_src = 1'b1; end
            OP_AND:         begin ctrl.unit = UNIT_LOGIC; ctrl.lfn = LG_AND; end
            OP_OR:          begin ctrl.unit = UNIT_LOGIC; ctrl.lfn = LG_OR; end
            OP_XOR:         begin ctrl.unit = UNIT_LOGIC; ctrl.lfn = LG_XOR; end
            OP_ANDI:        begin ctrl.unit = UNIT_LOGIC; ctrl.lfn = LG_AND; ctrl.imm_src = 1'b1; ctrl.imm_zext = 1'b1; end
            OP_ORI:         begin ctrl.unit = UNIT_LOGIC; ctrl.lfn = LG_OR;  ctrl.imm_src = 1'b1; ctrl.imm_zext = 1'b1; end
            OP_XORI:        begin ctrl.unit = UNIT_LOGIC; ctrl.lfn = LG_XOR; ctrl.imm_src = 1'b1; ctrl.imm_zext = 1'b1; end
            OP_LT_S:        begin ctrl.unit = UNIT_CMP; ctrl.sub = 1'b1; end
            OP_LT_U:        begin ctrl.unit = UNIT_CMP; ctrl.sub = 1'b1; ctrl.cmp_uns = 1'b1; end
            OP_LTI_S:       begin ctrl.unit = UNIT_CMP; ctrl.sub = 1'b1; ctrl.imm_src = 1'b1; end
            OP_LTI_U:       begin ctrl.unit = UNIT_CMP; ctrl.sub = 1'b1; ctrl.imm_src = 1'b1; ctrl.cmp_uns = 1'b1; end
            OP_MOV_NZ:      begin ctrl.unit = UNIT_MOVE; end
            OP_MOV_Z:       begin ctrl.unit = UNIT_MOVE; ctrl.mov_zero = 1'b1; end
            OP_UPPER_IMM:   begin ctrl.unit = UNIT_UPPER; end
            default: begin
                if (op_code[OPW-1:OPW-2] == OP_SHIFT_BASE[OPW-1:OPW-2] && sh_kind <= 3'd5) begin
                    ctrl.unit     = UNIT_SHIFT;
                    ctrl.sh_reg   = op_code[3];
                    ctrl.word     = (sh_kind < 3'd3);
                    ctrl.sh_left  = (sh_kind == 3'd0) || (sh_kind == 3'd3);
                    ctrl.sh_arith = (sh_kind == 3'd2) || (sh_kind == 3'd5);
                end
            end
        endcase
    end

endmodule

// File: rtl/alu_dw_adder.sv
module alu_dw_adder
    import alu_dw_pkg::*;
(
    input  logic [XLEN-1:0] x,
    input  logic [XLEN-1:0] y,
    input  logic            sub,
    input  logic            word,
    output logic [XLEN-1:0] sum,
    output logic            ovf,
    output logic            lt_signed,
    output logic            lt_unsigned
);

    logic [XLEN-1:0] y_eff;
    logic [XLEN-1:0] raw;
    logic            cout;
    logic            ovf_w;
    logic            ovf_d;

    assign y_eff = sub ? ~y : y;
    assign {cout, raw} = {1'b0, x} + {1'b0, y_eff} + {{XLEN{1'b0}}, sub};

    assign ovf_w = (x[WLEN-1] == y_eff[WLEN-1]) && (raw[WLEN-1] != x[WLEN-1]);
    assign ovf_d = (x[XLEN-1] == y_eff[XLEN-1]) && (raw[XLEN-1] != x[XLEN-1]);

    assign ovf         = word ? ovf_w : ovf_d;
    assign sum         = word ? sext_word(raw) : raw;
    assign lt_signed   = raw[XLEN-1] ^ ovf_d;
    assign lt_unsigned = ~cout;

    always_comb begin : chk_adder
        // R1: subtracting a value from itself always gives zero, without overflow
        p_self_sub_zero_r1: assert (!(sub && x == y) || (sum == '0 && !ovf))
            else $error("self subtraction not zero");
        // R5: equal operands are never less than each other
        p_equal_not_less_r5: assert (!(sub && x == y) || (!lt_signed && !lt_unsigned))
            else $error("equal operands compare less");
    end

endmodule

// File: rtl/alu_dw_shifter.sv
module alu_dw_shifter
    import alu_dw_pkg::*;
(
    input  logic [XLEN-1:0] val,
    input  logic [SHW-1:0]  amt,
    input  logic            left,
    input  logic            arith,
    input  logic            word,
    output logic [XLEN-1:0] res
);

    logic [XLEN-1:0] prep;
    logic [XLEN-1:0] src;
    logic [SHW-1:0]  amt_eff;
    logic            fill;
    logic [XLEN-1:0] stage [SHW+1];
    logic [XLEN-1:0] out_raw;

    always_comb begin
        if (word && !left) begin
            prep = arith ? sext_word(val) : {{(XLEN-WLEN){1'b0}}, val[WLEN-1:0]};
        end else begin
            prep = val;
        end
    end

    assign amt_eff = word ? {{(SHW-WSHW){1'b0}}, amt[WSHW-1:0]} : amt;
    assign src     = left ? bit_reverse(prep) : prep;
    assign fill    = arith & ~left & src[XLEN-1];
    assign stage[0] = src;

    for (genvar k = 0; k < SHW; k++) begin : g_stage
        localparam int STEP = 1 << k;
        assign stage[k+1] = amt_eff[k] ? {{STEP{fill}}, stage[k][XLEN-1:STEP]} : stage[k];
    end

    assign out_raw = left ? bit_reverse(stage[SHW]) : stage[SHW];
    assign res     = word ? sext_word(out_raw) : out_raw;

    always_comb begin : chk_shifter
        // R9: a doubleword shift by zero leaves the value unchanged
        p_zero_amount_identity_r9: assert (!(amt_eff == '0 && !word) || res == val)
            else $error("zero shift altered value");
        // R9: arithmetic right shift of a negative doubleword stays negative
        p_arith_keeps_sign_r9: assert (!(arith && !left && !word && val[XLEN-1]) || res[XLEN-1])
            else $error("arithmetic shift lost sign");
        // R10: word results are sign-extended from bit 31
        p_word_sign_ext_r10: assert (!word || res[XLEN-1:WLEN] == {(XLEN-WLEN){res[WLEN-1]}})
            else $error("word shift not sign-extended");
    end

endmodule

// File: rtl/alu_dual_width.sv
module alu_dual_width
    import alu_dw_pkg::*;
(
    input  logic [OPW-1:0]  op_code,
    input  logic [XLEN-1:0] op_a,
    input  logic [XLEN-1:0] op_b,
    input  logic [IMMW-1:0] imm,
    output logic [XLEN-1:0] result,
    output logic            wr_en,
    output logic            ovf_trap
);

    alu_ctrl_t       ctrl;
    logic [XLEN-1:0] imm_s;
    logic [XLEN-1:0] imm_z;
    logic [XLEN-1:0] opnd2;
    logic [XLEN-1:0] add_sum;
    logic            add_ovf;
    logic            lt_s;
    logic            lt_u;
    logic [XLEN-1:0] sh_res;
    logic [SHW-1:0]  sh_amt;
    logic [XLEN-1:0] logic_res;
    logic            b_zero;

    alu_dw_decode u_decode (
        .op_code (op_code),
        .ctrl    (ctrl)
    );

    assign imm_s = {{(XLEN-IMMW){imm[IMMW-1]}}, imm};
    assign imm_z = {{(XLEN-IMMW){1'b0}}, imm};
    assign opnd2 = ctrl.imm_src ? (ctrl.imm_zext ? imm_z : imm_s) : op_b;

    alu_dw_adder u_adder (
        .x           (op_a),
        .y           (opnd2),
        .sub         (ctrl.sub),
        .word        (ctrl.word && ctrl.unit == UNIT_ADD),
        .sum         (add_sum),
        .ovf         (add_ovf),
        .lt_signed   (lt_s),
        .lt_unsigned (lt_u)
    );

    assign sh_amt = ctrl.sh_reg ? op_b[SHW-1:0] : imm[SHW-1:0];

    alu_dw_shifter u_shifter (
        .val   (op_a),
        .amt   (sh_amt),
        .left  (ctrl.sh_left),
        .arith (ctrl.sh_arith),
        .word  (ctrl.word),
        .res   (sh_res)
    );

    always_comb begin
        case (ctrl.lfn)
            LG_OR:   logic_res = op_a | opnd2;
            LG_XOR:  logic_res = op_a ^ opnd2;
            default: logic_res = op_a & opnd2;
        endcase
    end

    assign b_zero = (op_b == '0);

    always_comb begin
        result   = '0;
        wr_en    = 1'b0;
        ovf_trap = 1'b0;
        case (ctrl.unit)
            UNIT_ADD: begin
                result   = add_sum;
                ovf_trap = ctrl.trap_en & add_ovf;
                wr_en    = ~(ctrl.trap_en & add_ovf);
            end
            UNIT_LOGIC: begin
                result = logic_res;
                wr_en  = 1'b1;
            end
            UNIT_CMP: begin
                result = {{(XLEN-1){1'b0}}, (ctrl.cmp_uns ? lt_u : lt_s)};
                wr_en  = 1'b1;
            end
            UNIT_MOVE: begin
                result = op_a;
                wr_en  = ctrl.mov_zero ? b_zero : ~b_zero;
            end
            UNIT_UPPER: begin
                result = sext_word({{(XLEN-WLEN){1'b0}}, imm, {(WLEN-IMMW){1'b0}}});
                wr_en  = 1'b1;
            end
            UNIT_SHIFT: begin
                result = sh_res;
                wr_en  = 1'b1;
            end
            default: ;
        endcase
    end

    always_comb begin : chk_top
        // R2: a trap always suppresses the register write
        p_trap_blocks_write_r2: assert (!ovf_trap || !wr_en)
            else $error("trap with write enabled");
        // R3: only the signed trapping codes may raise a trap
        p_trap_only_signed_r3: assert (!ovf_trap ||
                op_code == OP_ADD_W_TRAP  || op_code == OP_ADD_D_TRAP ||
                op_code == OP_SUB_W_TRAP  || op_code == OP_SUB_D_TRAP ||
                op_code == OP_ADDI_W_TRAP || op_code == OP_ADDI_D_TRAP)
            else $error("trap from non-trapping code");
        // R7: move-on-zero writes exactly when the condition operand is zero
        p_move_zero_gate_r7: assert (op_code != OP_MOV_Z || wr_en == (op_b == '0))
            else $error("move-on-zero gate wrong");
        // R7: move-on-non-zero writes exactly when the condition operand is non-zero
        p_move_nz_gate_r7: assert (op_code != OP_MOV_NZ || wr_en == (op_b != '0))
            else $error("move-on-non-zero gate wrong");
        // R8: upper-immediate result has clear low half and a sign-extended top
        p_upper_shape_r8: assert (op_code != OP_UPPER_IMM ||
                (result[IMMW-1:0] == '0 && result[XLEN-1:WLEN] == {(XLEN-WLEN){result[WLEN-1]}}))
            else $error("upper immediate malformed");
        // R5: a compare result is only ever 0 or 1
        p_compare_boolean_r5: assert (!(op_code inside {OP_LT_S, OP_LT_U, OP_LTI_S, OP_LTI_U}) ||
                result[XLEN-1:1] == '0)
            else $error("compare result not boolean");
    end

endmodule

// File: tb/alu_dual_width_tb.sv
module alu_dual_width_tb;
    import alu_dw_pkg::*;

    logic            clk = 1'b0;
    logic [5:0]      op_code;
    logic [63:0]     op_a;
    logic [63:0]     op_b;
    logic [15:0]     imm;
    logic [63:0]     result;
    logic            wr_en;
    logic            ovf_trap;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    alu_dual_width u_dut (
        .op_code  (op_code),
        .op_a     (op_a),
        .op_b     (op_b),
        .imm      (imm),
        .result   (result),
        .wr_en    (wr_en),
        .ovf_trap (ovf_trap)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000 && !done) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: run did not complete (actual cycles %0d, expected < 190000)", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    function automatic logic [63:0] sx32(input logic [31:0] v);
        return {{32{v[31]}}, v};
    endfunction

    task automatic model(input logic [5:0] op, input logic [63:0] a, input logic [63:0] b,
                         input logic [15:0] k, output logic [63:0] r, output logic w,
                         output logic t, output string tag);
        logic [63:0]        simm;
        logic [63:0]        zimm;
        logic [63:0]        rhs;
        longint             s32;
        logic signed [64:0] s65;
        logic signed [31:0] sw;
        logic [5:0]         amt;
        logic [2:0]         kind;
        simm = {{48{k[15]}}, k};
        zimm = {48'b0, k};
        r = '0; w = 1'b0; t = 1'b0; tag = "R11";
        if (op <= 6'd11) begin
            tag = op[0] ? "R1/R3" : "R1/R2";
            rhs = (op >= 6'd8) ? simm : b;
            if (op inside {6'd0, 6'd1, 6'd4, 6'd5, 6'd8, 6'd9}) begin
                if (op == 6'd4 || op == 6'd5)
                    s32 = longint'($signed(a[31:0])) - longint'($signed(rhs[31:0]));
                else
                    s32 = longint'($signed(a[31:0])) + longint'($signed(rhs[31:0]));
                r = sx32(s32[31:0]);
                t = !op[0] && (s32 > 64'sd2147483647 || s32 < -64'sd2147483648);
            end else begin
                if (op == 6'd6 || op == 6'd7)
                    s65 = $signed({a[63], a}) - $signed({rhs[63], rhs});
                else
                    s65 = $signed({a[63], a}) + $signed({rhs[63], rhs});
                r = s65[63:0];
                t = !op[0] && (s65[64] != s65[63]);
            end
            w = !t;
        end else if (op >= 6'd12 && op <= 6'd17) begin
            tag = "R4";
            rhs = (op >= 6'd15) ? zimm : b;
            case (op)
                6'd12, 6'd15: r = a & rhs;
                6'd13, 6'd16: r = a | rhs;
                default:      r = a ^ rhs;
            endcase
            w = 1'b1;
        end else if (op >= 6'd18 && op <= 6'd21) begin
            tag = (op <= 6'd19) ? "R5" : "R6";
            rhs = (op <= 6'd19) ? b : simm;
            if (op == 6'd18 || op == 6'd20) r = {63'b0, $signed(a) < $signed(rhs)};
            else                            r = {63'b0, a < rhs};
            w = 1'b1;
        end else if (op == 6'd22 || op == 6'd23) begin
            tag = "R7";
            r = a;
            w = (op == 6'd22) ? (b != 0) : (b == 0);
        end else if (op == 6'd24) begin
            tag = "R8";
            r = sx32({k, 16'h0000});
            w = 1'b1;
        end else if (op[5:4] == 2'b10 && op[2:0] <= 3'd5) begin
            kind = op[2:0];
            amt  = op[3] ? b[5:0] : k[5:0];
            w = 1'b1;
            if (kind < 3'd3) begin
                tag = "R9/R10";
                amt = {1'b0, amt[4:0]};
                sw  = $signed(a[31:0]);
                case (kind)
                    3'd0:    r = sx32(a[31:0] << amt);
                    3'd1:    r = sx32(a[31:0] >> amt);
                    default: r = sx32(sw >>> amt);
                endcase
            end else begin
                tag = "R9";
                case (kind)
                    3'd3:    r = a << amt;
                    3'd4:    r = a >> amt;
                    default: r = $signed(a) >>> amt;
                endcase
            end
        end
    endtask

    task automatic run_one(input logic [5:0] op, input logic [63:0] a, input logic [63:0] b,
                           input logic [15:0] k);
        logic [63:0] er;
        logic        ew;
        logic        et;
        string       tag;
        @(negedge clk);
        op_code = op; op_a = a; op_b = b; imm = k;
        #1;
        model(op, a, b, k, er, ew, et, tag);
        n_tests = n_tests + 1;
        if (result !== er || wr_en !== ew || ovf_trap !== et) begin
            n_fail = n_fail + 1;
            $display("FAIL %s op=%0d a=%h b=%h imm=%h actual r=%h we=%b trap=%b expected r=%h we=%b trap=%b",
                     tag, op, a, b, k, result, wr_en, ovf_trap, er, ew, et);
        end
    endtask

    logic [63:0] vals [14];
    logic [15:0] imms [7];

    initial begin
        vals[0]  = 64'h0;
        vals[1]  = 64'h1;
        vals[2]  = 64'hFFFF_FFFF_FFFF_FFFF;
        vals[3]  = 64'h0000_0000_7FFF_FFFF;
        vals[4]  = 64'h0000_0000_8000_0000;
        vals[5]  = 64'hFFFF_FFFF_8000_0000;
        vals[6]  = 64'h7FFF_FFFF_FFFF_FFFF;
        vals[7]  = 64'h8000_0000_0000_0000;
        vals[8]  = 64'h1234_5678_9ABC_DEF0;
        vals[9]  = 64'hFEDC_BA98_F654_3210;
        vals[10] = 64'h0000_0000_FFFF_FFFF;
        vals[11] = 64'h20;
        vals[12] = 64'h5;
        vals[13] = 64'h3F;
        imms[0] = 16'h0000;
        imms[1] = 16'h0001;
        imms[2] = 16'h7FFF;
        imms[3] = 16'h8000;
        imms[4] = 16'hFFFF;
        imms[5] = 16'h001F;
        imms[6] = 16'h0025;
        op_code = 6'd63; op_a = '0; op_b = '0; imm = '0;

        // R11: idle state with an undefined code, all outputs quiet
        run_one(6'd63, 64'hDEAD_BEEF_0000_0001, 64'h2, 16'h1234);

        for (int op = 0; op < 64; op++) begin
            for (int ia = 0; ia < 14; ia++) begin
                for (int ib = 0; ib < 14; ib++) begin
                    for (int ik = 0; ik < 7; ik++) begin
                        run_one(6'(op), vals[ia], vals[ib], imms[ik]);
                    end
                end
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule